// File: doc/BRIEF.md
# 1-Wire ROM Search Sequencer

This block takes the bit-level work of a 1-Wire ROM search away from the host. The host first sends the bus reset and the search command itself. It then raises the search-mode input and writes one byte for every four ID bit positions.

For each position the block asks the slot generator for two read slots: the ID bit and then its complement. It picks a direction from the two values it reads and the host's route choice, and asks for one write slot carrying that direction. When the four positions of a byte are finished, it hands back a byte that interleaves the direction taken with a discrepancy flag for each position. Sixteen bytes in and sixteen bytes out make one pass over a 64-bit ID.

The block talks to the slot generator through a single-slot request interface. A read slot is requested as a slot that writes 1, and the bus level is sampled during that slot. How the host picks the next path from the returned flags is outside the block.

Top module: `onewire_search_accel`

## Requirements
- R1: After reset, tx_ready_o, slot_req_o and rx_valid_o are 0. Search mode is entered on the clock edge that first sees srch_on_i high after it was low. From that point tx_ready_o is 1 whenever no byte is in progress.
- R2: In a written byte, bit 2k+1 is the route choice for position k of that byte (k = 0..3, position 0 first on the bus). The even bits have no effect on any slot or result.
- R3: Each position runs exactly three slots in this order: a read of the ID bit, a read of its complement, and a write. Both reads are requested with slot_wr_bit_o = 1.
- R4: The write slot carries the route choice when both reads are 0. It carries the first read value when the two reads differ. It carries 1 when both reads are 1.
- R5: In a returned byte, bit 2k is the discrepancy flag for position k (1 when the two reads were equal, otherwise 0). Bit 2k+1 is the direction written for that position.
- R6: rx_valid_o pulses for exactly one cycle, in the cycle after the edge that completes the 12th slot of the byte. rx_byte_o is valid in that cycle and slot_req_o is then 0.
- R7: Once a position has read 1 on both reads, every later write slot and every later returned path bit is 1, until search mode is left.
- R8: Entering search mode clears the latched error, so a fresh pass returns the true path again.
- R9: If bus_rst_i is high, or srch_on_i is low, at a clock edge, the block leaves search mode at that edge. slot_req_o is 0 from the next cycle, the partial byte is dropped without an rx_valid_o pulse, and tx_ready_o stays 0 until the next entry.
- R10: slot_req_o is a level that stays high from the edge that accepts a byte until the edge where the last slot's slot_done_i is seen. Each cycle in which slot_done_i is high ends exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_on_i | input | 1 | Search-mode level from the host; a rising edge enters the mode |
| bus_rst_i | input | 1 | Pulse: a bus reset is starting, which ends search mode |
| tx_valid_i | input | 1 | Host byte with route choices is offered |
| tx_byte_i | input | 8 | Route choices in the odd bits |
| tx_ready_o | output | 1 | Block accepts a byte this cycle |
| rx_valid_o | output | 1 | One-cycle pulse: result byte is posted |
| rx_byte_o | output | 8 | Path bits (odd) and discrepancy flags (even) |
| slot_req_o | output | 1 | Request level towards the slot generator |
| slot_wr_bit_o | output | 1 | Bit to write in the current slot (1 for read slots) |
| slot_done_i | input | 1 | The slot generator finished the current slot |
| slot_rd_bit_i | input | 1 | Bus level sampled in the finished slot |

## Verification
The assertions assume that slot_done_i only rises while slot_req_o is high, and once per slot. They also assume that the host offers a byte only while tx_ready_o is high and never starts a bus reset on the same edge as a mode entry. The bench keeps to these assumptions with a slot responder that waits a fixed number of cycles after seeing the request before it pulses done for one cycle. The host tasks raise tx_valid_i only while waiting for tx_ready_o, and bus_rst_i and srch_on_i are changed in separate steps. The responder models four devices on a wired-AND bus, including a phase in which they stop answering.

// File: rtl/srch_pkg.sv
package srch_pkg;
   typedef enum logic [1:0] {
      SP_IDLE = 2'd0,
      SP_RD0  = 2'd1,
      SP_RD1  = 2'd2,
      SP_WR   = 2'd3
   } srch_phase_t;
endpackage

// File: rtl/srch_mode_ctl.sv
module srch_mode_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic on_i,
   input  logic bus_rst_i,
   output logic active_o,
   output logic keep_o,
   output logic enter_o
);
   logic on_q;

   assign enter_o = on_i && !on_q && !bus_rst_i;
   assign keep_o  = active_o && on_i && !bus_rst_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q     <= 1'b0;
         active_o <= 1'b0;
      end else begin
         on_q <= on_i;
         if (!on_i || bus_rst_i)
            active_o <= 1'b0;
         else if (enter_o)
            active_o <= 1'b1;
      end
   end

   // R9
   leave_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_i || bus_rst_i) |=> !active_o);
   // R1
   enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_i && !on_q && !bus_rst_i) |=> active_o);
endmodule

// File: rtl/srch_pick.sv
module srch_pick (
   input  logic b0_i,
   input  logic b1_i,
   input  logic choice_i,
   input  logic err_i,
   output logic wbit_o,
   output logic disc_o,
   output logic nores_o
);
   always_comb begin
      nores_o = b0_i && b1_i;
      disc_o  = (b0_i == b1_i);
      if (err_i || nores_o)
         wbit_o = 1'b1;
      else if (b0_i != b1_i)
         wbit_o = b0_i;
      else
         wbit_o = choice_i;
   end
endmodule

// File: rtl/srch_seq.sv
module srch_seq
   import srch_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              keep_i,
   input  logic              enter_i,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic              tx_ready_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              slot_req_o,
   output logic              slot_wr_bit_o,
   input  logic              slot_done_i,
   input  logic              slot_rd_bit_i
);
   localparam int POS = DATA_W / 2;
   localparam int PW  = (POS > 1) ? $clog2(POS) : 1;
   localparam logic [PW-1:0] LAST = PW'(POS - 1);

   srch_phase_t       ph_q;
   logic [PW-1:0]     pos_q;
   logic [POS-1:0]    choice_q;
   logic [POS-1:0]    choice_in;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_nx;
   logic              b0_q;
   logic              wbit_q;
   logic              disc_q;
   logic              err_q;
   logic              pk_wbit;
   logic              pk_disc;
   logic              pk_nores;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("srch_seq: DATA_W must be even and at least 4");
      end
      for (genvar k = 0; k < POS; k++) begin : g_lane
         assign choice_in[k]    = tx_byte_i[2*k+1];
         assign acc_nx[2*k]     = (pos_q == PW'(k)) ? disc_q : acc_q[2*k];
         assign acc_nx[2*k+1]   = (pos_q == PW'(k)) ? wbit_q : acc_q[2*k+1];
      end
   endgenerate

   srch_pick u_pick (
      .b0_i     (b0_q),
      .b1_i     (slot_rd_bit_i),
      .choice_i (choice_q[pos_q]),
      .err_i    (err_q),
      .wbit_o   (pk_wbit),
      .disc_o   (pk_disc),
      .nores_o  (pk_nores)
   );

   assign tx_ready_o    = active_i && (ph_q == SP_IDLE);
   assign slot_req_o    = (ph_q != SP_IDLE);
   assign slot_wr_bit_o = (ph_q == SP_WR) ? wbit_q : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= SP_IDLE;
         pos_q      <= '0;
         choice_q   <= '0;
         acc_q      <= '0;
         b0_q       <= 1'b0;
         wbit_q     <= 1'b1;
         disc_q     <= 1'b0;
         err_q      <= 1'b0;
         rx_valid_o <= 1'b0;
         rx_byte_o  <= '0;
      end else begin
         rx_valid_o <= 1'b0;
         if (enter_i)
            err_q <= 1'b0;
         if (!keep_i) begin
            ph_q <= SP_IDLE;
         end else begin
            unique case (ph_q)
               SP_IDLE: if (tx_valid_i) begin
                  choice_q <= choice_in;
                  pos_q    <= '0;
                  acc_q    <= '0;
                  ph_q     <= SP_RD0;
               end
               SP_RD0: if (slot_done_i) begin
                  b0_q <= slot_rd_bit_i;
                  ph_q <= SP_RD1;
               end
               SP_RD1: if (slot_done_i) begin
                  wbit_q <= pk_wbit;
                  disc_q <= pk_disc;
                  if (pk_nores)
                     err_q <= 1'b1;
                  ph_q <= SP_WR;
               end
               SP_WR: if (slot_done_i) begin
                  acc_q <= acc_nx;
                  if (pos_q == LAST) begin
                     rx_valid_o <= 1'b1;
                     rx_byte_o  <= acc_nx;
                     ph_q       <= SP_IDLE;
                  end else begin
                     pos_q <= pos_q + 1'b1;
                     ph_q  <= SP_RD0;
                  end
               end
               default: ph_q <= SP_IDLE;
            endcase
         end
      end
   end

   // R6
   post_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> ($past(slot_done_i) && !slot_req_o));
   // R7
   err_forces_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && ph_q == SP_WR) |-> slot_wr_bit_o);
   // R3
   read_writes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req_o && $past(slot_done_i) && $past(ph_q) == SP_WR) |-> slot_wr_bit_o);
   // R10
   done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_done_i |-> slot_req_o);
endmodule

// File: rtl/onewire_search_accel.sv
module onewire_search_accel #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srch_on_i,
   input  logic              bus_rst_i,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic              tx_ready_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              slot_req_o,
   output logic              slot_wr_bit_o,
   input  logic              slot_done_i,
   input  logic              slot_rd_bit_i
);
   logic active;
   logic keep;
   logic enter;

   srch_mode_ctl u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_i      (srch_on_i),
      .bus_rst_i (bus_rst_i),
      .active_o  (active),
      .keep_o    (keep),
      .enter_o   (enter)
   );

   srch_seq #(.DATA_W(DATA_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .active_i      (active),
      .keep_i        (keep),
      .enter_i       (enter),
      .tx_valid_i    (tx_valid_i),
      .tx_byte_i     (tx_byte_i),
      .tx_ready_o    (tx_ready_o),
      .rx_valid_o    (rx_valid_o),
      .rx_byte_o     (rx_byte_o),
      .slot_req_o    (slot_req_o),
      .slot_wr_bit_o (slot_wr_bit_o),
      .slot_done_i   (slot_done_i),
      .slot_rd_bit_i (slot_rd_bit_i)
   );

   // R9
   abort_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> (!slot_req_o && !rx_valid_o && !tx_ready_o));
   // R1
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_o |-> !slot_req_o);
endmodule

// File: tb/onewire_search_accel_bench.sv
module onewire_search_accel_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic srch_on = 1'b0;
   logic bus_rst = 1'b0;
   logic tx_valid = 1'b0;
   logic [7:0] tx_byte = '0;
   logic slot_done = 1'b0;
   logic slot_rd = 1'b1;
   logic tx_ready, rx_valid, slot_req, slot_wbit;
   logic [7:0] rx_byte;

   always #(CLK_PERIOD/2) clk = ~clk;

   onewire_search_accel u_onewire_search_accel (
      .clk(clk), .rst_n(rst_n), .srch_on_i(srch_on), .bus_rst_i(bus_rst),
      .tx_valid_i(tx_valid), .tx_byte_i(tx_byte), .tx_ready_o(tx_ready),
      .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .slot_req_o(slot_req),
      .slot_wr_bit_o(slot_wbit), .slot_done_i(slot_done), .slot_rd_bit_i(slot_rd)
   );

   int checks = 0;
   int fails = 0;
   logic [63:0] dev_id [4];
   logic [3:0] dev_live = '1;
   bit present = 1'b1;
   bit m_active = 0, m_busy = 0, m_err = 0, m_rx = 0, done_drv = 0, prev_on = 0;
   bit b0m = 0, b1m = 0, wexp = 1;
   int lat = 0, slot_k = 0, byte_idx = 0;
   logic [7:0] cur_tx = '0, m_acc = '0, m_last = '0;
   logic [7:0] rxq [$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit bus_read(input int n, input bit inv);
      bit v = 1'b1;
      for (int i = 0; i < 4; i++)
         if (present && dev_live[i]) v &= inv ? ~dev_id[i][n] : dev_id[i][n];
      return v;
   endfunction

   // reference model and slot responder, compared every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         int ph, pos, n;
         bit abort;
         slot_done = 1'b0;
         slot_rd = 1'b1;
         m_rx = 0;
         if (done_drv) begin
            done_drv = 0;
            ph = slot_k % 3;
            pos = slot_k / 3;
            if (ph == 1) begin
               if (b0m && b1m) m_err = 1;
               wexp = m_err ? 1'b1 : ((b0m != b1m) ? b0m : cur_tx[2*pos+1]);
            end else if (ph == 2) begin
               m_acc[2*pos] = (b0m == b1m);
               m_acc[2*pos+1] = wexp;
            end
            slot_k++;
            if (slot_k == 12) begin
               m_busy = 0; m_rx = 1; m_last = m_acc; slot_k = 0; byte_idx++;
            end
         end
         chk(slot_req == m_busy, "R10 request level", slot_req, m_busy);
         chk(rx_valid == m_rx, "R6 result pulse", rx_valid, m_rx);
         if (rx_valid) begin
            chk(rx_byte == m_last, "R5 result byte", rx_byte, m_last);
            rxq.push_back(rx_byte);
         end
         chk(tx_ready == (m_active && !m_busy), "R1 ready", tx_ready, m_active && !m_busy);
         abort = bus_rst || !srch_on;
         if (tx_valid && tx_ready && !abort) begin
            m_busy = 1; cur_tx = tx_byte; slot_k = 0; m_acc = '0; lat = 0;
         end else if (abort) begin
            m_busy = 0; slot_k = 0; lat = 0;
         end else if (m_busy && slot_req) begin
            lat++;
            if (lat >= LAT) begin
               lat = 0;
               ph = slot_k % 3;
               n = byte_idx * 4 + slot_k / 3;
               if (ph == 0) begin
                  chk(slot_wbit == 1'b1, "R3 first read writes 1", slot_wbit, 1);
                  b0m = bus_read(n, 0); slot_rd = b0m;
               end else if (ph == 1) begin
                  chk(slot_wbit == 1'b1, "R3 second read writes 1", slot_wbit, 1);
                  b1m = bus_read(n, 1); slot_rd = b1m;
               end else begin
                  chk(slot_wbit == wexp, "R4 R7 write direction", slot_wbit, wexp);
                  for (int i = 0; i < 4; i++)
                     if (dev_id[i][n] != wexp) dev_live[i] = 1'b0;
                  slot_rd = slot_wbit;
               end
               slot_done = 1'b1;
               done_drv = 1;
            end
         end
         if (srch_on && !prev_on && !bus_rst) begin m_active = 1; m_err = 0; end
         if (!srch_on || bus_rst) m_active = 0;
         prev_on = srch_on;
      end
   end

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   task automatic start_pass();
      @(posedge clk); #1 srch_on = 1'b0;
      repeat (2) @(posedge clk);
      #1 srch_on = 1'b1;
      dev_live = '1; byte_idx = 0; present = 1'b1;
      repeat (2) @(posedge clk);
   endtask

   task automatic offer(input logic [7:0] b);
      @(posedge clk); #1 tx_valid = 1'b1; tx_byte = b;
      do @(negedge clk); while (!tx_ready);
      @(posedge clk); #1 tx_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
      int s = rxq.size();
      offer(b);
      while (rxq.size() == s) @(negedge clk);
      r = rxq.pop_front();
   endtask

   task automatic run_pass(input logic [63:0] choice, input int gone_byte,
                           output logic [63:0] path, output logic [63:0] disc);
      path = '0; disc = '0;
      for (int j = 0; j < 16; j++) begin
         logic [7:0] b, r;
         b = (j % 2) ? 8'h55 : 8'h00;   // even bits are filler (R2)
         for (int k = 0; k < 4; k++) b[2*k+1] = choice[4*j+k];
         present = (j != gone_byte);
         send_byte(b, r);
         for (int k = 0; k < 4; k++) begin
            path[4*j+k] = r[2*k+1];
            disc[4*j+k] = r[2*k];
         end
      end
      present = 1'b1;
   endtask

   function automatic bit is_dev(input logic [63:0] v);
      for (int i = 0; i < 4; i++) if (dev_id[i] == v) return 1;
      return 0;
   endfunction

   initial begin
      logic [63:0] pa, da, pb, db, pc, dc, pd, dd, chb;
      int m, s;
      bit ok;
      dev_id[0] = 64'hA5C3_1F07_9B2E_4D61;
      dev_id[1] = 64'hA5C3_1F07_9B2E_4D63;
      dev_id[2] = 64'h0123_4567_89AB_CDEF;
      dev_id[3] = 64'hFEDC_BA98_7654_3210;
      repeat (3) @(posedge clk);
      #1;
      chk(tx_ready == 0, "R1 reset ready", tx_ready, 0);
      chk(slot_req == 0, "R1 reset request", slot_req, 0);
      chk(rx_valid == 0, "R1 reset result pulse", rx_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1 chk(tx_ready == 0, "R1 not ready before entry", tx_ready, 0);

      // pass A: all choices 0
      start_pass();
      run_pass(64'h0, -1, pa, da);
      chk(is_dev(pa), "R4 pass A finds a device", pa, dev_id[0]);
      // pass B: take the other branch at the highest open discrepancy
      m = -1;
      for (int i = 63; i >= 0; i--) if (da[i] && m < 0) m = i;
      chb = (pa & ((64'd1 << m) - 64'd1)) | (64'd1 << m);
      start_pass();
      run_pass(chb, -1, pb, db);
      chk(is_dev(pb) && pb != pa, "R2 R4 pass B finds another device", pb, pa);
      chk(pb[m] == 1'b1, "R2 route choice followed at discrepancy", pb[m], 1);

      // pass C: devices stop answering during byte 2
      start_pass();
      run_pass(64'h0, 2, pc, dc);
      ok = 1;
      for (int i = 8; i < 64; i++) if (!pc[i]) ok = 0;
      chk(ok, "R7 path bits stay 1 after error", pc[63:8], 56'hFF_FFFF_FFFF_FFFF);
      chk(dc[8] == 1'b1, "R5 discrepancy set on no response", dc[8], 1);

      // pass D: re-entry clears the error
      start_pass();
      run_pass(64'h0, -1, pd, dd);
      chk(pd == pa, "R8 error cleared on entry", pd, pa);

      // abort by bus reset mid-byte
      start_pass();
      s = rxq.size();
      offer(8'h00);
      repeat (10) @(posedge clk);
      #1 bus_rst = 1'b1;
      @(posedge clk); #1 bus_rst = 1'b0;
      repeat (60) @(posedge clk);
      #1;
      chk(rxq.size() == s, "R9 no result after bus reset", rxq.size(), s);
      chk(tx_ready == 0, "R9 mode left after bus reset", tx_ready, 0);
      chk(slot_req == 0, "R9 request dropped", slot_req, 0);

      // abort by clearing the mode input mid-byte
      start_pass();
      s = rxq.size();
      offer(8'hAA);
      repeat (12) @(posedge clk);
      #1 srch_on = 1'b0;
      repeat (60) @(posedge clk);
      #1;
      chk(rxq.size() == s, "R9 no result after mode off", rxq.size(), s);
      chk(slot_req == 0, "R9 request dropped on mode off", slot_req, 0);

      summary();
      $finish;
   end
endmodule